// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor's execute stage. It decides, on each cycle in which the pipeline asks it to, whether a synchronous exception or an external hardware interrupt is to be entered. It then computes the complete processor state that entry produces. The inputs are the current status register, vector base, program counter, stack pointer (R15), delay-slot flags and a sleep indication. A pending exception code comes from the decode and fault logic. An interrupt level and vector come from an external priority encoder.

All results are registered and appear in a single cycle: the saved status, saved PC, saved stack pointer, the exception and interrupt event codes, the new status register and the new PC. A one-cycle `ev_taken` pulse marks each entry. An exception raised while events are blocked is promoted to a reset. An exception in a delay slot saves the PC of the branch so that the branch runs again. Each class of event has its own entry address.

Top module: `exc_entry_seq`

## Requirements
- R1: When `req` is high and both `exc_pend` and an eligible interrupt are present, the exception is entered (`ev_is_irq`=0) and the interrupt is not taken in that cycle.
- R2: When SR bit 28 (block bit) is set and an exception with a code other than 0x1E0 is entered, it is entered as code 0x000, with PC 0xA0000000. Code 0x1E0 under the block bit is entered with its own code and vector.
- R3: While SR bit 28 is set, an interrupt is not taken unless `sleep_in` is high. In that case `ev_taken` stays low and `pc_next` holds.
- R4: An interrupt is taken only when `irq_lvl` is strictly greater than SR bits 7:4. On entry `irq_event` gets `irq_vec`, `pc_next` becomes VBR+0x600, and `exc_event` keeps its previous value.
- R5: On every entry, `saved_sr` gets the incoming SR and `saved_sp` gets R15. `sr_next` is the incoming SR with bits 28, 29 and 30 set.
- R6: If any bit of `slot_in` is set at entry, `saved_pc` is the PC minus 2, and `slot_flags` reads 0 after entry. When no event is taken, `slot_flags` shows `slot_in` from the previous cycle.
- R7: Reset-class codes 0x000, 0x020 and 0x140 load PC 0xA0000000. They clear SR bit 15 and set SR bits 7:4 to 0xF.
- R8: An exception writes its code to `exc_event`. Codes 0x040 and 0x060 enter at VBR+0x400. Every other non-reset code enters at VBR+0x100, and `irq_event` keeps its value.
- R9: For code 0x160, `saved_pc` is advanced by 2 after any delay-slot rewind.
- R10: All outputs change at the clock edge that samples `req`. `ev_taken` is high for exactly the cycles following such an edge with an eligible event. With no request, or no eligible event, all state outputs hold.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Evaluate pending events this cycle |
| exc_pend | input | 1 | A synchronous exception is pending |
| exc_code | input | CODE_W | Code of the pending exception |
| irq_pend | input | 1 | The priority encoder has a source |
| irq_lvl | input | LVL_W | Priority level of that source |
| irq_vec | input | CODE_W | Vector code of that source |
| sr_in | input | XLEN | Current status register |
| vbr_in | input | XLEN | Vector base register |
| pc_in | input | XLEN | PC of the faulting or next instruction |
| r15_in | input | XLEN | Current stack pointer |
| slot_in | input | SLOT_W | Delay-slot flags |
| sleep_in | input | 1 | Processor is sleeping |
| ev_taken | output | 1 | Entry happened at the last edge |
| ev_is_irq | output | 1 | Last entry was an interrupt |
| saved_sr | output | XLEN | Saved status register |
| saved_pc | output | XLEN | Saved program counter |
| saved_sp | output | XLEN | Saved stack pointer |
| exc_event | output | CODE_W | Exception event code |
| irq_event | output | CODE_W | Interrupt event code |
| sr_next | output | XLEN | Status register after entry |
| pc_next | output | XLEN | Handler address |
| slot_flags | output | SLOT_W | Delay-slot flags after this cycle |

## Verification
A wrong arbitration or classification decision shows up on the edge right after the request. It appears as a handler address in `pc_next` that differs from the class the code belongs to, or as an `ev_is_irq` that contradicts the priority and mask rules. A wrong save path corrupts `saved_pc` or `saved_sr` in that same cycle. An event-code register updated by the wrong kind of entry stays hidden until a later entry of the other kind. The bench therefore checks the untouched register after mixed sequences.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
   localparam int SR_FD        = 15;
   localparam int SR_BL        = 28;
   localparam int SR_RB        = 29;
   localparam int SR_MD        = 30;
   localparam int SR_IMASK_LSB = 4;

   localparam logic [31:0] RESET_PC = 32'hA000_0000;
   localparam logic [31:0] OFS_GEN  = 32'h0000_0100;
   localparam logic [31:0] OFS_TLB  = 32'h0000_0400;
   localparam logic [31:0] OFS_IRQ  = 32'h0000_0600;

   localparam logic [11:0] C_POWERON  = 12'h000;
   localparam logic [11:0] C_MANUAL   = 12'h020;
   localparam logic [11:0] C_MULTIHIT = 12'h140;
   localparam logic [11:0] C_TLB_RD   = 12'h040;
   localparam logic [11:0] C_TLB_WR   = 12'h060;
   localparam logic [11:0] C_TRAP     = 12'h160;
   localparam logic [11:0] C_BREAK    = 12'h1E0;

   typedef enum logic [1:0] {EV_NONE, EV_EXC, EV_IRQ} ev_kind_e;
   typedef enum logic [1:0] {CL_RESET, CL_TLBMISS, CL_TRAP, CL_GENERAL} ev_class_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_seq_pkg::*;
#(
   parameter int CODE_W = 12,
   parameter int LVL_W  = 4
) (
   input  logic              req,
   input  logic              exc_pend,
   input  logic [CODE_W-1:0] exc_code,
   input  logic              irq_pend,
   input  logic [LVL_W-1:0]  irq_lvl,
   input  logic [LVL_W-1:0]  imask,
   input  logic              blocked,
   input  logic              sleep_in,
   output ev_kind_e          kind,
   output logic [CODE_W-1:0] eff_code
);
   logic irq_ok;

   always_comb begin
      irq_ok   = irq_pend && (irq_lvl > imask) && (!blocked || sleep_in);
      kind     = EV_NONE;
      eff_code = exc_code;
      if (req && exc_pend) begin
         kind = EV_EXC;
         if (blocked && exc_code != CODE_W'(C_BREAK))
            eff_code = CODE_W'(C_POWERON);
      end else if (req && irq_ok) begin
         kind = EV_IRQ;
      end
   end
endmodule

// File: rtl/exc_target.sv
module exc_target
   import exc_seq_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int CODE_W      = 12,
   parameter int SLOT_W      = 3,
   parameter int LVL_W       = 4,
   parameter int INSN_BYTES  = 2,
   parameter bit REWIND_SLOT = 1'b1
) (
   input  ev_kind_e          kind,
   input  logic [CODE_W-1:0] code,
   input  logic [XLEN-1:0]   sr_in,
   input  logic [XLEN-1:0]   vbr_in,
   input  logic [XLEN-1:0]   pc_in,
   input  logic [SLOT_W-1:0] slot_in,
   output logic [XLEN-1:0]   new_sr,
   output logic [XLEN-1:0]   new_spc,
   output logic [XLEN-1:0]   new_pc
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   logic [XLEN-1:0] rewound;
   logic [XLEN-1:0] base_spc;
   ev_class_e       cls;

   generate
      if (REWIND_SLOT) begin : g_rewind
         assign rewound = pc_in - STEP;
      end else begin : g_keep
         assign rewound = pc_in;
      end
   endgenerate

   always_comb begin
      if (code == CODE_W'(C_POWERON) || code == CODE_W'(C_MANUAL) ||
          code == CODE_W'(C_MULTIHIT))
         cls = CL_RESET;
      else if (code == CODE_W'(C_TLB_RD) || code == CODE_W'(C_TLB_WR))
         cls = CL_TLBMISS;
      else if (code == CODE_W'(C_TRAP))
         cls = CL_TRAP;
      else
         cls = CL_GENERAL;
   end

   always_comb begin
      base_spc = (|slot_in) ? rewound : pc_in;
      new_sr   = sr_in;
      new_sr[SR_BL] = 1'b1;
      new_sr[SR_RB] = 1'b1;
      new_sr[SR_MD] = 1'b1;
      new_spc  = base_spc;
      new_pc   = vbr_in + XLEN'(OFS_GEN);
      if (kind == EV_IRQ) begin
         new_pc = vbr_in + XLEN'(OFS_IRQ);
      end else begin
         case (cls)
            CL_RESET: begin
               new_sr[SR_FD] = 1'b0;
               new_sr[SR_IMASK_LSB +: LVL_W] = '1;
               new_pc = XLEN'(RESET_PC);
            end
            CL_TLBMISS: new_pc  = vbr_in + XLEN'(OFS_TLB);
            CL_TRAP:    new_spc = base_spc + STEP;
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_seq_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int CODE_W      = 12,
   parameter int LVL_W       = 4,
   parameter int SLOT_W      = 3,
   parameter int INSN_BYTES  = 2,
   parameter bit REWIND_SLOT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              exc_pend,
   input  logic [CODE_W-1:0] exc_code,
   input  logic              irq_pend,
   input  logic [LVL_W-1:0]  irq_lvl,
   input  logic [CODE_W-1:0] irq_vec,
   input  logic [XLEN-1:0]   sr_in,
   input  logic [XLEN-1:0]   vbr_in,
   input  logic [XLEN-1:0]   pc_in,
   input  logic [XLEN-1:0]   r15_in,
   input  logic [SLOT_W-1:0] slot_in,
   input  logic              sleep_in,
   output logic              ev_taken,
   output logic              ev_is_irq,
   output logic [XLEN-1:0]   saved_sr,
   output logic [XLEN-1:0]   saved_pc,
   output logic [XLEN-1:0]   saved_sp,
   output logic [CODE_W-1:0] exc_event,
   output logic [CODE_W-1:0] irq_event,
   output logic [XLEN-1:0]   sr_next,
   output logic [XLEN-1:0]   pc_next,
   output logic [SLOT_W-1:0] slot_flags
);
   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("exc_entry_seq: XLEN must cover status bit 30 and the reset PC");
      end
      if (CODE_W < 9) begin : g_bad_code
         $error("exc_entry_seq: CODE_W too narrow for event codes");
      end
      if (SR_IMASK_LSB + LVL_W > SR_FD) begin : g_bad_lvl
         $error("exc_entry_seq: mask field overlaps other status bits");
      end
      if (SLOT_W < 1 || INSN_BYTES < 1) begin : g_bad_slot
         $error("exc_entry_seq: SLOT_W and INSN_BYTES must be positive");
      end
   endgenerate

   ev_kind_e          kind;
   logic [CODE_W-1:0] eff_code;
   logic [XLEN-1:0]   new_sr, new_spc, new_pc;

   exc_arbiter #(.CODE_W(CODE_W), .LVL_W(LVL_W)) u_arb (
      .req      (req),
      .exc_pend (exc_pend),
      .exc_code (exc_code),
      .irq_pend (irq_pend),
      .irq_lvl  (irq_lvl),
      .imask    (sr_in[SR_IMASK_LSB +: LVL_W]),
      .blocked  (sr_in[SR_BL]),
      .sleep_in (sleep_in),
      .kind     (kind),
      .eff_code (eff_code)
   );

   exc_target #(
      .XLEN(XLEN), .CODE_W(CODE_W), .SLOT_W(SLOT_W), .LVL_W(LVL_W),
      .INSN_BYTES(INSN_BYTES), .REWIND_SLOT(REWIND_SLOT)
   ) u_tgt (
      .kind    (kind),
      .code    (eff_code),
      .sr_in   (sr_in),
      .vbr_in  (vbr_in),
      .pc_in   (pc_in),
      .slot_in (slot_in),
      .new_sr  (new_sr),
      .new_spc (new_spc),
      .new_pc  (new_pc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_taken   <= 1'b0;
         ev_is_irq  <= 1'b0;
         saved_sr   <= '0;
         saved_pc   <= '0;
         saved_sp   <= '0;
         exc_event  <= '0;
         irq_event  <= '0;
         sr_next    <= '0;
         pc_next    <= '0;
         slot_flags <= '0;
      end else begin
         ev_taken   <= (kind != EV_NONE);
         slot_flags <= (kind != EV_NONE) ? '0 : slot_in;
         if (kind != EV_NONE) begin
            ev_is_irq <= (kind == EV_IRQ);
            saved_sr  <= sr_in;
            saved_pc  <= new_spc;
            saved_sp  <= r15_in;
            sr_next   <= new_sr;
            pc_next   <= new_pc;
         end
         if (kind == EV_EXC) exc_event <= eff_code;
         if (kind == EV_IRQ) irq_event <= irq_vec;
      end
   end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
   import exc_seq_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int CODE_W = 12,
   parameter int LVL_W  = 4,
   parameter int SLOT_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic              exc_pend,
   input logic [LVL_W-1:0]  irq_lvl,
   input logic [XLEN-1:0]   sr_in,
   input logic [XLEN-1:0]   vbr_in,
   input logic [XLEN-1:0]   r15_in,
   input logic              sleep_in,
   input logic              ev_taken,
   input logic              ev_is_irq,
   input logic [XLEN-1:0]   saved_sr,
   input logic [XLEN-1:0]   saved_pc,
   input logic [XLEN-1:0]   saved_sp,
   input logic [CODE_W-1:0] exc_event,
   input logic [XLEN-1:0]   sr_next,
   input logic [XLEN-1:0]   pc_next,
   input logic [SLOT_W-1:0] slot_flags
);
   AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_taken && $past(exc_pend) |-> !ev_is_irq); // R1
   AST_BL_IRQ_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      ev_taken && ev_is_irq && $past(sr_in[SR_BL]) |-> $past(sleep_in)); // R3
   AST_IRQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      ev_taken && ev_is_irq |-> $past(irq_lvl) > $past(sr_in[SR_IMASK_LSB +: LVL_W])); // R4
   AST_IRQ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      ev_taken && ev_is_irq |-> pc_next == $past(vbr_in) + XLEN'(OFS_IRQ)); // R4
   AST_SAVE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_taken |-> saved_sr == $past(sr_in) && saved_sp == $past(r15_in)); // R5
   AST_ENTRY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_taken |-> sr_next[SR_BL] && sr_next[SR_RB] && sr_next[SR_MD]); // R5
   AST_SLOT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      ev_taken |-> slot_flags == '0); // R6
   AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      ev_taken && !ev_is_irq && exc_event == '0 |->
      pc_next == XLEN'(RESET_PC) && !sr_next[SR_FD] &&
      sr_next[SR_IMASK_LSB +: LVL_W] == '1); // R7
   AST_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ev_taken |-> $past(req)); // R10
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_taken |-> $stable(pc_next) && $stable(saved_pc)); // R10
endmodule

bind exc_entry_seq exc_entry_chk #(
   .XLEN(XLEN), .CODE_W(CODE_W), .LVL_W(LVL_W), .SLOT_W(SLOT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .exc_pend(exc_pend), .irq_lvl(irq_lvl),
   .sr_in(sr_in), .vbr_in(vbr_in), .r15_in(r15_in), .sleep_in(sleep_in),
   .ev_taken(ev_taken), .ev_is_irq(ev_is_irq), .saved_sr(saved_sr),
   .saved_pc(saved_pc), .saved_sp(saved_sp), .exc_event(exc_event),
   .sr_next(sr_next), .pc_next(pc_next), .slot_flags(slot_flags)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
   localparam logic [31:0] VBR = 32'h8C00_0000;
   localparam logic [31:0] PC  = 32'h0C00_1000;
   localparam logic [31:0] R15 = 32'h0CFF_FFF0;
   localparam logic [31:0] SA  = 32'h0000_8030;
   localparam logic [31:0] SB  = 32'h1000_0030;

   typedef struct packed {
      logic        exc;
      logic [11:0] code;
      logic        irq;
      logic [3:0]  lvl;
      logic [11:0] vec;
      logic [31:0] sr;
      logic        sleep;
      logic [2:0]  slot;
      logic        e_tk;
      logic        e_irq;
      logic [31:0] e_pc;
      logic [31:0] e_spc;
      logic [11:0] e_evt;
      logic [31:0] e_sr;
      logic [7:0]  rq;
   } row_t;

   localparam int NROWS = 18;
   localparam row_t TBL [NROWS] = '{
      '{1'b1,12'h040,1'b0,4'd0,12'h000,SA,1'b0,3'b000,1'b1,1'b0,32'h8C00_0400,PC,12'h040,32'h7000_8030,8'd8}, // R8
      '{1'b1,12'h060,1'b0,4'd0,12'h000,SA,1'b0,3'b000,1'b1,1'b0,32'h8C00_0400,PC,12'h060,32'h7000_8030,8'd8}, // R8
      '{1'b1,12'h0E0,1'b0,4'd0,12'h000,SA,1'b0,3'b000,1'b1,1'b0,32'h8C00_0100,PC,12'h0E0,32'h7000_8030,8'd8}, // R8
      '{1'b1,12'h160,1'b0,4'd0,12'h000,SA,1'b0,3'b000,1'b1,1'b0,32'h8C00_0100,32'h0C00_1002,12'h160,32'h7000_8030,8'd9}, // R9
      '{1'b1,12'h020,1'b0,4'd0,12'h000,SA,1'b0,3'b000,1'b1,1'b0,32'hA000_0000,PC,12'h020,32'h7000_00F0,8'd7}, // R7
      '{1'b1,12'h140,1'b0,4'd0,12'h000,SA,1'b0,3'b000,1'b1,1'b0,32'hA000_0000,PC,12'h140,32'h7000_00F0,8'd7}, // R7
      '{1'b1,12'h000,1'b0,4'd0,12'h000,SA,1'b0,3'b000,1'b1,1'b0,32'hA000_0000,PC,12'h000,32'h7000_00F0,8'd7}, // R7
      '{1'b0,12'h000,1'b1,4'd5,12'h3A0,SA,1'b0,3'b000,1'b1,1'b1,32'h8C00_0600,PC,12'h3A0,32'h7000_8030,8'd4}, // R4
      '{1'b0,12'h000,1'b1,4'd3,12'h3C0,SA,1'b0,3'b000,1'b0,1'b0,32'h0,32'h0,12'h0,32'h0,8'd4},               // R4 level equal to mask
      '{1'b1,12'h0A0,1'b1,4'd9,12'h3E0,SA,1'b0,3'b000,1'b1,1'b0,32'h8C00_0100,PC,12'h0A0,32'h7000_8030,8'd1}, // R1
      '{1'b1,12'h0E0,1'b0,4'd0,12'h000,SB,1'b0,3'b000,1'b1,1'b0,32'hA000_0000,PC,12'h000,32'h7000_00F0,8'd2}, // R2
      '{1'b1,12'h1E0,1'b0,4'd0,12'h000,SB,1'b0,3'b000,1'b1,1'b0,32'h8C00_0100,PC,12'h1E0,32'h7000_0030,8'd2}, // R2
      '{1'b0,12'h000,1'b1,4'd5,12'h200,SB,1'b0,3'b000,1'b0,1'b0,32'h0,32'h0,12'h0,32'h0,8'd3},               // R3
      '{1'b0,12'h000,1'b1,4'd5,12'h200,SB,1'b1,3'b000,1'b1,1'b1,32'h8C00_0600,PC,12'h200,32'h7000_0030,8'd3}, // R3
      '{1'b1,12'h0E0,1'b0,4'd0,12'h000,SA,1'b0,3'b001,1'b1,1'b0,32'h8C00_0100,32'h0C00_0FFE,12'h0E0,32'h7000_8030,8'd6}, // R6
      '{1'b1,12'h160,1'b0,4'd0,12'h000,SA,1'b0,3'b010,1'b1,1'b0,32'h8C00_0100,PC,12'h160,32'h7000_8030,8'd9}, // R9
      '{1'b0,12'h000,1'b1,4'd5,12'h240,SA,1'b0,3'b100,1'b1,1'b1,32'h8C00_0600,32'h0C00_0FFE,12'h240,32'h7000_8030,8'd6}, // R6
      '{1'b0,12'h000,1'b0,4'd0,12'h000,SA,1'b0,3'b101,1'b0,1'b0,32'h0,32'h0,12'h0,32'h0,8'd10}               // R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, exc_pend = 1'b0, irq_pend = 1'b0, sleep_in = 1'b0;
   logic [11:0] exc_code = '0, irq_vec = '0;
   logic [3:0]  irq_lvl = '0;
   logic [31:0] sr_in = '0, vbr_in = VBR, pc_in = PC, r15_in = R15;
   logic [2:0]  slot_in = '0;
   logic        ev_taken, ev_is_irq;
   logic [31:0] saved_sr, saved_pc, saved_sp, sr_next, pc_next;
   logic [11:0] exc_event, irq_event;
   logic [2:0]  slot_flags;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   exc_entry_seq u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .exc_pend(exc_pend), .exc_code(exc_code),
      .irq_pend(irq_pend), .irq_lvl(irq_lvl), .irq_vec(irq_vec), .sr_in(sr_in),
      .vbr_in(vbr_in), .pc_in(pc_in), .r15_in(r15_in), .slot_in(slot_in),
      .sleep_in(sleep_in), .ev_taken(ev_taken), .ev_is_irq(ev_is_irq),
      .saved_sr(saved_sr), .saved_pc(saved_pc), .saved_sp(saved_sp),
      .exc_event(exc_event), .irq_event(irq_event), .sr_next(sr_next),
      .pc_next(pc_next), .slot_flags(slot_flags)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] prev_pc;
      logic [11:0] keep_evt;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 ev_taken", {31'b0, ev_taken}, 32'h0);
      chk("R11 pc_next", pc_next, 32'h0);
      chk("R11 sr_next", sr_next, 32'h0);
      chk("R11 exc_event", {20'b0, exc_event}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NROWS; i++) begin
         string t;
         t = $sformatf("R%0d row%0d", TBL[i].rq, i);
         prev_pc  = pc_next;
         req      = 1'b1;
         exc_pend = TBL[i].exc;  exc_code = TBL[i].code;
         irq_pend = TBL[i].irq;  irq_lvl  = TBL[i].lvl;  irq_vec = TBL[i].vec;
         sr_in    = TBL[i].sr;   sleep_in = TBL[i].sleep; slot_in = TBL[i].slot;
         step();
         chk({t, " taken"}, {31'b0, ev_taken}, {31'b0, TBL[i].e_tk});
         if (TBL[i].e_tk) begin
            chk({t, " is_irq"}, {31'b0, ev_is_irq}, {31'b0, TBL[i].e_irq});
            chk({t, " pc"}, pc_next, TBL[i].e_pc);
            chk({t, " spc"}, saved_pc, TBL[i].e_spc);
            chk({t, " sr"}, sr_next, TBL[i].e_sr);
            chk({t, " ssr R5"}, saved_sr, TBL[i].sr);
            chk({t, " sgr R5"}, saved_sp, R15);
            chk({t, " slot R6"}, {29'b0, slot_flags}, 32'h0);
            if (TBL[i].e_irq) chk({t, " intevt"}, {20'b0, irq_event}, {20'b0, TBL[i].e_evt});
            else              chk({t, " expevt"}, {20'b0, exc_event}, {20'b0, TBL[i].e_evt});
         end else begin
            chk({t, " pc hold"}, pc_next, prev_pc);
            chk({t, " slot pass R6"}, {29'b0, slot_flags}, {29'b0, TBL[i].slot});
         end
      end

      // R10: no request, pending exception ignored
      slot_in = '0; sr_in = SA; exc_pend = 1'b1; exc_code = 12'h040; irq_pend = 1'b0;
      prev_pc = pc_next; keep_evt = exc_event; req = 1'b0;
      step();
      chk("R10 idle taken", {31'b0, ev_taken}, 32'h0);
      chk("R10 idle pc", pc_next, prev_pc);
      chk("R10 idle expevt", {20'b0, exc_event}, {20'b0, keep_evt});

      // R10: one pulse per request
      req = 1'b1; exc_code = 12'h0E0;
      step();
      chk("R10 pulse high", {31'b0, ev_taken}, 32'h1);
      req = 1'b0;
      step();
      chk("R10 pulse low", {31'b0, ev_taken}, 32'h0);

      // R4: interrupt leaves exception code
      req = 1'b1; exc_pend = 1'b0; irq_pend = 1'b1; irq_lvl = 4'd7; irq_vec = 12'h2A0;
      step();
      chk("R4 irq taken", {31'b0, ev_is_irq}, 32'h1);
      chk("R4 expevt kept", {20'b0, exc_event}, 32'h0E0);
      chk("R4 intevt", {20'b0, irq_event}, 32'h2A0);

      // R8: exception leaves interrupt code
      exc_pend = 1'b1; exc_code = 12'h060; irq_pend = 1'b0;
      step();
      chk("R8 expevt", {20'b0, exc_event}, 32'h060);
      chk("R8 intevt kept", {20'b0, irq_event}, 32'h2A0);
      chk("R8 pc", pc_next, 32'h8C00_0400);
      req = 1'b0; exc_pend = 1'b0;
      step();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule